// File: doc/BRIEF.md
# Address Window Decoder

This block steers each transaction on a system interconnect to a target. Software programs a bank of address windows. Each window holds an enable, a target ID, write and read security attributes, and an inclusive lower and upper limit at 1 MiB granularity. For every lookup the block compares address bits [35:20] against all enabled windows. It returns the target ID of the matching window with the lowest index. When no enabled window covers the address, it returns a programmable default target instead.

Lookups carry a write/read flag and a secure flag. The block raises a violation flag when a non-secure access reaches a window that protects that direction. The target is still reported in that case, so the fabric decides what to do with the violation.

A flat word-addressed register port gives read and write access to every field. Software can therefore save the whole configuration and restore it later. Lookup results and read data are both registered and appear one clock after their inputs. Reset is asynchronous and active-low, and its release is synchronised inside the block.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset, window 0 is enabled with target 0 and limits 0..0 (the first MiB). Every other window is disabled, every other register reads zero, and the default target is 0.
- R2: Register word index w*4+0 is window w's control register: bit 0 enable, bits [15:8] target. Index w*4+1 is security: bit 0 write-secure, bit 1 read-secure. Index w*4+2 is the low limit and w*4+3 the high limit, each holding the 1 MiB unit number in bits [19:4]. Index NUM_WIN*4 holds the default target in bits [7:0]. All bits not named here read as zero.
- R3: A window matches when it is enabled and low <= addr[35:20] <= high, with both limits inclusive.
- R4: A disabled window never matches. Clearing the enable leaves the window's limits, target and security settings as they were.
- R5: When several enabled windows match, the lowest-numbered window supplies the target.
- R6: When no enabled window matches, res_hit is 0 and res_tgt equals the default target.
- R7: res_viol is 1 only for a hit where a non-secure write reaches a write-secure window, or a non-secure read reaches a read-secure window. The target is reported unchanged. A secure access never flags a violation, and neither does a miss.
- R8: Lookup outputs and reg_rdata appear one clock after their inputs are sampled. They use the register contents from before any write made in that same cycle.
- R9: A write to a word index above NUM_WIN*4 changes no register, and such an index reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 6 | Register word index |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the index sampled on the previous clock |
| lk_addr | input | 36 | Lookup physical address |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| lk_secure | input | 1 | 1 = secure access |
| res_hit | output | 1 | An enabled window matched |
| res_tgt | output | 8 | Selected target ID |
| res_viol | output | 1 | Security violation on the matched window |

## Verification
Every result is due exactly one rising edge after its inputs are sampled: lookup target, hit and violation, as well as register read data. The bench drives inputs on the falling edge and computes the expected outputs from its model state before that cycle's write. It then compares them on the next falling edge, so a write and a lookup in the same cycle check R8 directly. After reset is released the synchronizer needs two rising edges before the registers leave reset, and the bench waits through that window before its first stimulus.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int REG_DW      = 32;
  localparam int GRAN_SHIFT  = 20;
  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_TGT_LSB = 8;
  localparam int SEC_WR_BIT  = 0;
  localparam int SEC_RD_BIT  = 1;
  localparam int LIM_LSB     = 4;
  localparam int DFLT_LSB    = 0;

  typedef enum logic [1:0] {
    SEL_CTL = 2'd0,
    SEL_SEC = 2'd1,
    SEL_LO  = 2'd2,
    SEL_HI  = 2'd3
  } awd_sel_e;
endpackage

// File: rtl/awd_regs.sv
module awd_regs
  import awd_pkg::*;
#(
  parameter int NW = 8,
  parameter int TW = 8,
  parameter int LW = 16,
  parameter int AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic              we,
  input  logic [REG_DW-1:0] wdata,
  output logic [REG_DW-1:0] rdata,
  output logic [NW-1:0]     win_en,
  output logic [NW*TW-1:0]  win_tgt,
  output logic [NW-1:0]     win_wsec,
  output logic [NW-1:0]     win_rsec,
  output logic [NW*LW-1:0]  win_lo,
  output logic [NW*LW-1:0]  win_hi,
  output logic [TW-1:0]     dflt_tgt
);
  localparam int GLOB_IDX = NW * 4;

  logic          en_q   [NW];
  logic          en_d   [NW];
  logic [TW-1:0] tgt_q  [NW];
  logic [TW-1:0] tgt_d  [NW];
  logic          ws_q   [NW];
  logic          ws_d   [NW];
  logic          rs_q   [NW];
  logic          rs_d   [NW];
  logic [LW-1:0] lo_q   [NW];
  logic [LW-1:0] lo_d   [NW];
  logic [LW-1:0] hi_q   [NW];
  logic [LW-1:0] hi_d   [NW];
  logic [TW-1:0] dflt_q;
  logic [TW-1:0] dflt_d;
  logic [REG_DW-1:0] rd_q;
  logic [REG_DW-1:0] rd_d;

  logic [AW-3:0] wsel;
  awd_sel_e      fsel;
  logic          is_win;
  logic          is_glob;

  assign wsel    = addr[AW-1:2];
  assign fsel    = awd_sel_e'(addr[1:0]);
  assign is_win  = (int'(addr) < GLOB_IDX);
  assign is_glob = (int'(addr) == GLOB_IDX);

  // next-state: writes
  always_comb begin
    for (int i = 0; i < NW; i++) begin
      en_d[i]  = en_q[i];
      tgt_d[i] = tgt_q[i];
      ws_d[i]  = ws_q[i];
      rs_d[i]  = rs_q[i];
      lo_d[i]  = lo_q[i];
      hi_d[i]  = hi_q[i];
      if (we && is_win && (int'(wsel) == i)) begin
        case (fsel)
          SEL_CTL: begin
            en_d[i]  = wdata[CTL_EN_BIT];
            tgt_d[i] = wdata[CTL_TGT_LSB +: TW];
          end
          SEL_SEC: begin
            ws_d[i] = wdata[SEC_WR_BIT];
            rs_d[i] = wdata[SEC_RD_BIT];
          end
          SEL_LO:  lo_d[i] = wdata[LIM_LSB +: LW];
          default: hi_d[i] = wdata[LIM_LSB +: LW];
        endcase
      end
    end
    dflt_d = dflt_q;
    if (we && is_glob) dflt_d = wdata[DFLT_LSB +: TW];
  end

  // next-state: readback
  always_comb begin
    rd_d = '0;
    for (int i = 0; i < NW; i++) begin
      if (is_win && (int'(wsel) == i)) begin
        case (fsel)
          SEL_CTL: begin
            rd_d[CTL_EN_BIT]        = en_q[i];
            rd_d[CTL_TGT_LSB +: TW] = tgt_q[i];
          end
          SEL_SEC: begin
            rd_d[SEC_WR_BIT] = ws_q[i];
            rd_d[SEC_RD_BIT] = rs_q[i];
          end
          SEL_LO:  rd_d[LIM_LSB +: LW] = lo_q[i];
          default: rd_d[LIM_LSB +: LW] = hi_q[i];
        endcase
      end
    end
    if (is_glob) rd_d[DFLT_LSB +: TW] = dflt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) begin
        en_q[i]  <= (i == 0);
        tgt_q[i] <= '0;
        ws_q[i]  <= 1'b0;
        rs_q[i]  <= 1'b0;
        lo_q[i]  <= '0;
        hi_q[i]  <= '0;
      end
      dflt_q <= '0;
      rd_q   <= '0;
    end else begin
      for (int i = 0; i < NW; i++) begin
        en_q[i]  <= en_d[i];
        tgt_q[i] <= tgt_d[i];
        ws_q[i]  <= ws_d[i];
        rs_q[i]  <= rs_d[i];
        lo_q[i]  <= lo_d[i];
        hi_q[i]  <= hi_d[i];
      end
      dflt_q <= dflt_d;
      rd_q   <= rd_d;
    end
  end

  for (genvar g = 0; g < NW; g++) begin : g_flat
    assign win_en[g]             = en_q[g];
    assign win_tgt[g*TW +: TW]   = tgt_q[g];
    assign win_wsec[g]           = ws_q[g];
    assign win_rsec[g]           = rs_q[g];
    assign win_lo[g*LW +: LW]    = lo_q[g];
    assign win_hi[g*LW +: LW]    = hi_q[g];
  end
  assign dflt_tgt = dflt_q;
  assign rdata    = rd_q;

  // R9: a write beyond the global register touches nothing
  a_r9_oob_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (int'(addr) > GLOB_IDX)) |=> ($stable(dflt_tgt) && $stable(win_en) && $stable(win_lo)));
endmodule

// File: rtl/awd_match.sv
module awd_match #(
  parameter int NW = 8,
  parameter int LW = 16
) (
  input  logic [NW-1:0]    win_en,
  input  logic [NW*LW-1:0] win_lo,
  input  logic [NW*LW-1:0] win_hi,
  input  logic [LW-1:0]    key,
  output logic [NW-1:0]    hit_vec
);
  for (genvar g = 0; g < NW; g++) begin : g_cmp
    logic above_lo;
    logic below_hi;
    assign above_lo   = (key >= win_lo[g*LW +: LW]);
    assign below_hi   = (key <= win_hi[g*LW +: LW]);
    assign hit_vec[g] = win_en[g] && above_lo && below_hi;
  end
endmodule

// File: rtl/awd_pick.sv
module awd_pick #(
  parameter int NW = 8,
  parameter int IW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic [NW-1:0] req,
  output logic          any,
  output logic [IW-1:0] idx
);
  // lowest index has priority: scan downwards, last assignment wins
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = NW - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
  import awd_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int TGT_W   = 8,
  parameter int ADDR_W  = 36,
  parameter int REG_AW  = $clog2(NUM_WIN * 4 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_write,
  input  logic              lk_secure,
  output logic              res_hit,
  output logic [TGT_W-1:0]  res_tgt,
  output logic              res_viol
);
  localparam int LIM_W = ADDR_W - GRAN_SHIFT;
  localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  logic [NUM_WIN-1:0]       win_en;
  logic [NUM_WIN*TGT_W-1:0] win_tgt;
  logic [NUM_WIN-1:0]       win_wsec;
  logic [NUM_WIN-1:0]       win_rsec;
  logic [NUM_WIN*LIM_W-1:0] win_lo;
  logic [NUM_WIN*LIM_W-1:0] win_hi;
  logic [TGT_W-1:0]         dflt_tgt;
  logic [NUM_WIN-1:0]       hit_vec;
  logic                     any_hit;
  logic [IDX_W-1:0]         win_idx;

  awd_regs #(.NW(NUM_WIN), .TW(TGT_W), .LW(LIM_W), .AW(REG_AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_i),
    .addr     (reg_addr),
    .we       (reg_we),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .win_en   (win_en),
    .win_tgt  (win_tgt),
    .win_wsec (win_wsec),
    .win_rsec (win_rsec),
    .win_lo   (win_lo),
    .win_hi   (win_hi),
    .dflt_tgt (dflt_tgt)
  );

  awd_match #(.NW(NUM_WIN), .LW(LIM_W)) u_match (
    .win_en  (win_en),
    .win_lo  (win_lo),
    .win_hi  (win_hi),
    .key     (lk_addr[ADDR_W-1:GRAN_SHIFT]),
    .hit_vec (hit_vec)
  );

  awd_pick #(.NW(NUM_WIN), .IW(IDX_W)) u_pick (
    .req (hit_vec),
    .any (any_hit),
    .idx (win_idx)
  );

  logic             hit_d, hit_q;
  logic [TGT_W-1:0] tgt_d, tgt_q;
  logic             viol_d, viol_q;

  always_comb begin
    hit_d  = any_hit;
    tgt_d  = any_hit ? win_tgt[win_idx*TGT_W +: TGT_W] : dflt_tgt;
    viol_d = any_hit && !lk_secure &&
             (lk_write ? win_wsec[win_idx] : win_rsec[win_idx]);
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      hit_q  <= 1'b0;
      tgt_q  <= '0;
      viol_q <= 1'b0;
    end else begin
      hit_q  <= hit_d;
      tgt_q  <= tgt_d;
      viol_q <= viol_d;
    end
  end

  assign res_hit  = hit_q;
  assign res_tgt  = tgt_q;
  assign res_viol = viol_q;

  a_r6_miss_default: assert property (@(posedge clk) disable iff (!rst_i)
    !res_hit |-> (res_tgt == $past(dflt_tgt)));
  a_r7_secure_clean: assert property (@(posedge clk) disable iff (!rst_i)
    $past(lk_secure) |-> !res_viol);
  a_r7_miss_clean: assert property (@(posedge clk) disable iff (!rst_i)
    !res_hit |-> !res_viol);
  a_r4_hit_needs_enable: assert property (@(posedge clk) disable iff (!rst_i)
    res_hit |-> ($past(win_en) != '0));
endmodule

// File: tb/tb_addr_window_decoder.sv
module tb_addr_window_decoder;
  logic        clk;
  logic        rst_n;
  logic [5:0]  reg_addr;
  logic        reg_we;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [35:0] lk_addr;
  logic        lk_write;
  logic        lk_secure;
  logic        res_hit;
  logic [7:0]  res_tgt;
  logic        res_viol;

  addr_window_decoder dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_addr(lk_addr),
    .lk_write(lk_write), .lk_secure(lk_secure), .res_hit(res_hit),
    .res_tgt(res_tgt), .res_viol(res_viol)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int nchk = 0;
  int nbad = 0;

  // behavioural model of the register set
  logic        m_en [8];
  logic [7:0]  m_tgt[8];
  logic        m_ws [8];
  logic        m_rs [8];
  logic [15:0] m_lo [8];
  logic [15:0] m_hi [8];
  logic [7:0]  m_dflt;

  function automatic logic [31:0] mread(int a);
    logic [31:0] r = '0;
    if (a < 32) begin
      int w = a / 4;
      case (a % 4)
        0: r = {16'h0, m_tgt[w], 7'h0, m_en[w]};
        1: r = {30'h0, m_rs[w], m_ws[w]};
        2: r = {12'h0, m_lo[w], 4'h0};
        default: r = {12'h0, m_hi[w], 4'h0};
      endcase
    end else if (a == 32) begin
      r = {24'h0, m_dflt};
    end
    return r;
  endfunction

  task automatic mwrite(int a, logic [31:0] d);
    if (a < 32) begin
      int w = a / 4;
      case (a % 4)
        0: begin m_en[w] = d[0]; m_tgt[w] = d[15:8]; end
        1: begin m_ws[w] = d[0]; m_rs[w] = d[1]; end
        2: m_lo[w] = d[19:4];
        default: m_hi[w] = d[19:4];
      endcase
    end else if (a == 32) begin
      m_dflt = d[7:0];
    end
  endtask

  task automatic chk(string tag, string what, int got, int exp);
    nchk++;
    if (got != exp) begin
      nbad++;
      $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
    end
  endtask

  // one clock: expectation from pre-write model, then compare after the edge
  task automatic step(string tag);
    logic        e_hit = 1'b0;
    logic [7:0]  e_tgt = m_dflt;
    logic        e_viol = 1'b0;
    logic [31:0] e_rd;
    logic [15:0] key = lk_addr[35:20];
    for (int i = 0; i < 8; i++) begin
      if (!e_hit && m_en[i] && key >= m_lo[i] && key <= m_hi[i]) begin
        e_hit  = 1'b1;
        e_tgt  = m_tgt[i];
        e_viol = !lk_secure && (lk_write ? m_ws[i] : m_rs[i]);
      end
    end
    e_rd = mread(int'(reg_addr));
    if (reg_we) mwrite(int'(reg_addr), reg_wdata);
    @(posedge clk);
    @(negedge clk);
    chk(tag, "hit",   int'(res_hit),  int'(e_hit));
    chk(tag, "tgt",   int'(res_tgt),  int'(e_tgt));
    chk(tag, "viol",  int'(res_viol), int'(e_viol));
    chk(tag, "rdata", int'(reg_rdata), int'(e_rd));
  endtask

  task automatic wr(int a, logic [31:0] d, string tag);
    reg_addr = 6'(a); reg_wdata = d; reg_we = 1'b1;
    step(tag);
    reg_we = 1'b0;
  endtask

  task automatic rd(int a, string tag);
    reg_addr = 6'(a);
    step(tag);
  endtask

  task automatic look(int key, logic w, logic s, string tag);
    lk_addr = {16'(key), 20'hA5C3E}; lk_write = w; lk_secure = s;
    step(tag);
  endtask

  // window w registers: limits given in MiB units
  task automatic setwin(int w, int lo, int hi, int tgt, string tag);
    wr(w*4+2, 32'(lo) << 4, tag);
    wr(w*4+3, 32'(hi) << 4, tag);
    wr(w*4+0, (32'(tgt) << 8) | 32'h1, tag);
  endtask

  initial begin
    #(20 * 100000);
    nbad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_en[i] = (i == 0); m_tgt[i] = '0; m_ws[i] = 1'b0; m_rs[i] = 1'b0;
      m_lo[i] = '0; m_hi[i] = '0;
    end
    m_dflt = '0;
    rst_n = 1'b0; reg_addr = '0; reg_we = 1'b0; reg_wdata = '0;
    lk_addr = '0; lk_write = 1'b0; lk_secure = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs held in reset
    chk("R1", "hit_rst",  int'(res_hit),   0);
    chk("R1", "tgt_rst",  int'(res_tgt),   0);
    chk("R1", "rd_rst",   int'(reg_rdata), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset contents of every register, window 0 open on the first MiB
    for (int a = 0; a <= 32; a++) rd(a, "R1");
    look(0, 1'b0, 1'b0, "R1");
    look(1, 1'b0, 1'b0, "R1");

    // R2: field placement, unnamed bits read zero
    wr(4, 32'hFFFF_FFFF, "R2");
    rd(4, "R2");
    wr(5, 32'hFFFF_FFFF, "R2");
    rd(5, "R2");
    wr(6, 32'hFFFF_FFFF, "R2");
    rd(6, "R2");
    wr(7, 32'hFFFF_FFFF, "R2");
    wr(32, 32'hFFFF_FF5A, "R2");
    rd(32, "R2");
    wr(5, 32'h0, "R2");
    wr(32, 32'h0, "R2");

    // R3: inclusive limits, window 1 on units 16..31
    setwin(1, 16, 31, 8'h11, "R3");
    look(15, 1'b0, 1'b0, "R3");
    look(16, 1'b0, 1'b0, "R3");
    look(31, 1'b1, 1'b0, "R3");
    look(32, 1'b0, 1'b0, "R3");
    look(16'hFFFF, 1'b0, 1'b0, "R3");

    // R4: disabling keeps other fields
    wr(4, 32'h0000_1100, "R4");
    look(20, 1'b0, 1'b0, "R4");
    rd(6, "R4");
    rd(7, "R4");
    rd(4, "R4");
    wr(4, 32'h0000_1101, "R4");
    look(20, 1'b0, 1'b0, "R4");

    // R5: overlaps resolved by lowest index
    setwin(3, 40, 60, 8'h33, "R5");
    setwin(2, 50, 70, 8'h22, "R5");
    look(45, 1'b0, 1'b0, "R5");
    look(55, 1'b0, 1'b0, "R5");
    look(65, 1'b0, 1'b0, "R5");
    setwin(5, 0, 0, 8'h55, "R5");
    look(0, 1'b0, 1'b0, "R5");
    setwin(7, 100, 200, 8'h77, "R5");
    look(150, 1'b0, 1'b0, "R5");

    // R6: misses go to the programmed default
    wr(32, 32'h0000_007E, "R6");
    look(300, 1'b0, 1'b0, "R6");
    look(35, 1'b1, 1'b1, "R6");

    // R7: security attributes on window 2 (units 50..70)
    wr(9, 32'h1, "R7");
    look(55, 1'b1, 1'b0, "R7");
    look(55, 1'b0, 1'b0, "R7");
    look(55, 1'b1, 1'b1, "R7");
    wr(9, 32'h2, "R7");
    look(55, 1'b0, 1'b0, "R7");
    look(55, 1'b1, 1'b0, "R7");
    look(55, 1'b0, 1'b1, "R7");
    wr(9, 32'h3, "R7");
    look(300, 1'b1, 1'b0, "R7");
    look(65, 1'b0, 1'b0, "R7");

    // R8: lookup in the same cycle as a write sees the old setting
    lk_addr = {16'd55, 20'h0}; lk_write = 1'b0; lk_secure = 1'b1;
    wr(8, 32'h0000_2200, "R8");
    look(55, 1'b0, 1'b1, "R8");
    reg_addr = 6'd8; reg_wdata = 32'h0000_2201; reg_we = 1'b1;
    step("R8");
    reg_we = 1'b0;
    look(55, 1'b0, 1'b1, "R8");

    // R9: indices beyond the global register
    wr(40, 32'hFFFF_FFFF, "R9");
    rd(40, "R9");
    wr(63, 32'hFFFF_FFFF, "R9");
    rd(63, "R9");
    rd(32, "R9");
    look(300, 1'b0, 1'b0, "R9");
    for (int a = 0; a <= 32; a++) rd(a, "R9");

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule